// File: doc/BRIEF.md
# Trap Entry Sequencer

This block carries out the hardware side of entering a software trap on a 32-bit processor. When the core raises a request, the block takes a snapshot of the trap number, the trap instruction's PC, the status word, the supervisor stack pointer and the vector table base. It then saves context on the supervisor stack through a single word-wide memory port. The status word is saved first, at the stack pointer minus 4. The return address is saved next, at the stack pointer minus 8. Last, the block reads the handler address from a vector table.

Vector table entries are counted downward from the top of a 1 KiB table, so trap 0 occupies the highest word. When the sequence completes, the block presents the handler PC, the lowered stack pointer and the updated status word for one cycle.

A debug flavour of the request always uses vector 9. It loads the interrupt level mask with 4 and does not clear the interrupt enable bit.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset the block is idle: `done_o` and `mem_req_o` are low.
- R2: The first memory access is a write of the pre-trap status word to address `ssp_i - 4`.
- R3: The second access is a write of `pc_i + 2` to address `ssp_i - 8`, and `new_ssp_o` at completion equals `ssp_i - 8` (all modulo 2^32).
- R4: The third access is a read at `tbr_i + 1024 - 4*(num_i + 1)` modulo 2^32, with `num_i` taken as unsigned. The word returned for it appears on `new_pc_o` at completion.
- R5: For an ordinary trap (`dbg_i` = 0), `new_ps_o` equals the pre-trap status word with bit 5 (stack select) and bit 4 (interrupt enable) cleared. All other bits are unchanged.
- R6: For a debug trap (`dbg_i` = 1), the read uses vector 9 whatever `num_i` is. `new_ps_o` has bit 5 cleared, bits 20:16 (interrupt level mask) set to 4, and every other bit, bit 4 included, unchanged.
- R7: While `mem_ready_i` is low, a pending access holds its request, direction, address and write data, and the sequence does not advance.
- R8: `done_o` is high for exactly one cycle per trap, and the result outputs are valid in that cycle.
- R9: A request raised while a sequence is in progress, including during the completion cycle, is ignored. Its input values do not affect the running sequence, and after completion the block returns to idle with no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Trap entry request, accepted only when idle |
| dbg_i | input | 1 | Selects the debug-trap flavour |
| num_i | input | 8 | Trap number |
| pc_i | input | 32 | PC of the trap instruction |
| ps_i | input | 32 | Status word before the trap |
| ssp_i | input | 32 | Supervisor stack pointer |
| tbr_i | input | 32 | Vector table base |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Byte address of the access |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with ready |
| mem_ready_i | input | 1 | Completes the current access |
| done_o | output | 1 | One-cycle completion pulse |
| new_pc_o | output | 32 | Handler address |
| new_ssp_o | output | 32 | Updated supervisor stack pointer |
| new_ps_o | output | 32 | Updated status word |

## Verification
Random trap numbers, PCs, status words, stack pointers and table bases are mixed with directed corner cases, and the memory responds with random wait states. Trap numbers 0 and 255 distinguish a correct downward index from an upward or off-by-one one. A table base near the top of the address space and a stack pointer of 4 expose missing modulo-2^32 wrap. Debug traps with arbitrary numbers show whether vector 9 is forced and the interrupt enable bit kept. A run that holds the request high and changes every input mid-sequence shows whether late requests are really ignored.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
  localparam int WORD_W = 32;
  localparam int WORD_BYTES = WORD_W / 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_PS,
    ST_PUSH_PC,
    ST_FETCH_VEC,
    ST_DONE
  } seq_state_e;

  // Entry n counted down from the top of the table.
  function automatic logic [WORD_W-1:0] vec_entry_addr(
    input logic [WORD_W-1:0] base,
    input logic [WORD_W-1:0] vec,
    input logic [WORD_W-1:0] tbl_bytes
  );
    return base + tbl_bytes - ((vec + 1) * WORD_BYTES);
  endfunction

  function automatic logic [WORD_W-1:0] stack_slot(
    input logic [WORD_W-1:0] sp,
    input logic [WORD_W-1:0] depth
  );
    return sp - (depth * WORD_BYTES);
  endfunction

  function automatic logic [WORD_W-1:0] return_pc(input logic [WORD_W-1:0] pc);
    return pc + 2;
  endfunction
endpackage

// File: rtl/trap_seq_fsm.sv
module trap_seq_fsm
  import trap_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  input  logic       mem_ready_i,
  output seq_state_e state_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (req_i)       state_d = ST_PUSH_PS;
      ST_PUSH_PS:   if (mem_ready_i) state_d = ST_PUSH_PC;
      ST_PUSH_PC:   if (mem_ready_i) state_d = ST_FETCH_VEC;
      ST_FETCH_VEC: if (mem_ready_i) state_d = ST_DONE;
      ST_DONE:                       state_d = ST_IDLE;
      default:                       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/trap_seq_agu.sv
module trap_seq_agu
  import trap_seq_pkg::*;
#(
  parameter int TABLE_BYTES = 1024
) (
  input  seq_state_e        state_i,
  input  logic [WORD_W-1:0] ssp_i,
  input  logic [WORD_W-1:0] tbr_i,
  input  logic [WORD_W-1:0] vec_i,
  input  logic [WORD_W-1:0] pc_i,
  input  logic [WORD_W-1:0] ps_i,
  output logic              req_o,
  output logic              we_o,
  output logic [WORD_W-1:0] addr_o,
  output logic [WORD_W-1:0] wdata_o
);
  localparam logic [WORD_W-1:0] TBL_SIZE = WORD_W'(TABLE_BYTES);

  always_comb begin
    req_o   = 1'b0;
    we_o    = 1'b0;
    addr_o  = '0;
    wdata_o = '0;
    unique case (state_i)
      ST_PUSH_PS: begin
        req_o   = 1'b1;
        we_o    = 1'b1;
        addr_o  = stack_slot(ssp_i, 1);
        wdata_o = ps_i;
      end
      ST_PUSH_PC: begin
        req_o   = 1'b1;
        we_o    = 1'b1;
        addr_o  = stack_slot(ssp_i, 2);
        wdata_o = return_pc(pc_i);
      end
      ST_FETCH_VEC: begin
        req_o  = 1'b1;
        addr_o = vec_entry_addr(tbr_i, vec_i, TBL_SIZE);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/trap_seq_psmod.sv
module trap_seq_psmod
  import trap_seq_pkg::*;
#(
  parameter int S_POS   = 5,
  parameter int I_POS   = 4,
  parameter int ILM_LSB = 16,
  parameter int ILM_W   = 5,
  parameter int DBG_ILM = 4
) (
  input  logic              dbg_i,
  input  logic [WORD_W-1:0] ps_i,
  output logic [WORD_W-1:0] ps_o
);
  localparam logic [ILM_W-1:0] ILM_VAL = ILM_W'(DBG_ILM);

  always_comb begin
    ps_o = ps_i;
    ps_o[S_POS] = 1'b0;
    if (dbg_i) ps_o[ILM_LSB +: ILM_W] = ILM_VAL;
    else       ps_o[I_POS] = 1'b0;
  end
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_seq_pkg::*;
#(
  parameter int NUM_W       = 8,
  parameter int TABLE_BYTES = 1024,
  parameter int DBG_VEC     = 9,
  parameter int DBG_ILM     = 4,
  parameter int S_POS       = 5,
  parameter int I_POS       = 4,
  parameter int ILM_LSB     = 16,
  parameter int ILM_W       = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              dbg_i,
  input  logic [NUM_W-1:0]  num_i,
  input  logic [31:0]       pc_i,
  input  logic [31:0]       ps_i,
  input  logic [31:0]       ssp_i,
  input  logic [31:0]       tbr_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [31:0]       mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i,
  input  logic              mem_ready_i,
  output logic              done_o,
  output logic [31:0]       new_pc_o,
  output logic [31:0]       new_ssp_o,
  output logic [31:0]       new_ps_o
);
  localparam logic [NUM_W-1:0] DBG_NUM = NUM_W'(DBG_VEC);

  seq_state_e        state;
  logic              cap_dbg;
  logic [NUM_W-1:0]  cap_num;
  logic [WORD_W-1:0] cap_pc, cap_ps, cap_ssp, cap_tbr, vec_q;

  // Named events for the checker.
  logic evt_accept, evt_push_ps, evt_push_pc, evt_fetch, evt_done;
  assign evt_accept  = (state == ST_IDLE) && req_i;
  assign evt_push_ps = (state == ST_PUSH_PS);
  assign evt_push_pc = (state == ST_PUSH_PC);
  assign evt_fetch   = (state == ST_FETCH_VEC);
  assign evt_done    = (state == ST_DONE);

  trap_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .mem_ready_i (mem_ready_i),
    .state_o     (state)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_dbg <= 1'b0;
      cap_num <= '0;
      cap_pc  <= '0;
      cap_ps  <= '0;
      cap_ssp <= '0;
      cap_tbr <= '0;
    end else if (evt_accept) begin
      cap_dbg <= dbg_i;
      cap_num <= dbg_i ? DBG_NUM : num_i;
      cap_pc  <= pc_i;
      cap_ps  <= ps_i;
      cap_ssp <= ssp_i;
      cap_tbr <= tbr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        vec_q <= '0;
    else if (evt_fetch && mem_ready_i) vec_q <= mem_rdata_i;
  end

  trap_seq_agu #(.TABLE_BYTES(TABLE_BYTES)) u_agu (
    .state_i (state),
    .ssp_i   (cap_ssp),
    .tbr_i   (cap_tbr),
    .vec_i   ({{(WORD_W-NUM_W){1'b0}}, cap_num}),
    .pc_i    (cap_pc),
    .ps_i    (cap_ps),
    .req_o   (mem_req_o),
    .we_o    (mem_we_o),
    .addr_o  (mem_addr_o),
    .wdata_o (mem_wdata_o)
  );

  trap_seq_psmod #(
    .S_POS(S_POS), .I_POS(I_POS), .ILM_LSB(ILM_LSB), .ILM_W(ILM_W), .DBG_ILM(DBG_ILM)
  ) u_ps (
    .dbg_i (cap_dbg),
    .ps_i  (cap_ps),
    .ps_o  (new_ps_o)
  );

  assign done_o    = evt_done;
  assign new_pc_o  = vec_q;
  assign new_ssp_o = stack_slot(cap_ssp, 2);
endmodule

// File: rtl/trap_entry_seq_chk.sv
module trap_entry_seq_chk #(
  parameter int S_POS = 5
) (
  input logic        clk,
  input logic        rst_n,
  input logic        evt_push_ps,
  input logic        evt_push_pc,
  input logic        evt_fetch,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic        mem_ready_i,
  input logic [31:0] mem_addr_o,
  input logic [31:0] mem_wdata_o,
  input logic        done_o,
  input logic [31:0] new_ssp_o,
  input logic [31:0] new_ps_o
);
  logic [31:0] last_wr_addr;
  logic [31:0] first_wr_addr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_wr_addr  <= '0;
      first_wr_addr <= '0;
    end else if (mem_req_o && mem_we_o && mem_ready_i) begin
      last_wr_addr <= mem_addr_o;
      if (evt_push_ps) first_wr_addr <= mem_addr_o;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |-> !done_o && !mem_req_o); // R1
  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_push_pc && $rose(evt_push_pc)) |-> mem_addr_o == first_wr_addr - 32'd4); // R3
  AST_SSP_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> new_ssp_o == last_wr_addr); // R3
  AST_FETCH_READ: assert property (@(posedge clk) disable iff (!rst_n)
    evt_fetch |-> mem_req_o && !mem_we_o); // R4
  AST_S_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !new_ps_o[S_POS]); // R5
  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ready_i) |=> mem_req_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !mem_req_o); // R9
endmodule

bind trap_entry_seq trap_entry_seq_chk #(.S_POS(S_POS)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .evt_push_ps (evt_push_ps),
  .evt_push_pc (evt_push_pc),
  .evt_fetch   (evt_fetch),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_ready_i (mem_ready_i),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .done_o      (done_o),
  .new_ssp_o   (new_ssp_o),
  .new_ps_o    (new_ps_o)
);

// File: tb/trap_entry_seq_tb_top.sv
`timescale 1ns/1ps
module trap_entry_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_i = 1'b0, dbg_i = 1'b0;
  logic [7:0] num_i = '0;
  logic [31:0] pc_i = '0, ps_i = '0, ssp_i = '0, tbr_i = '0;
  logic mem_req_o, mem_we_o, mem_ready_i = 1'b0;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i = '0;
  logic done_o;
  logic [31:0] new_pc_o, new_ssp_o, new_ps_o;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #4 clk = ~clk;

  trap_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .dbg_i(dbg_i), .num_i(num_i),
    .pc_i(pc_i), .ps_i(ps_i), .ssp_i(ssp_i), .tbr_i(tbr_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ready_i(mem_ready_i),
    .done_o(done_o), .new_pc_o(new_pc_o), .new_ssp_o(new_ssp_o), .new_ps_o(new_ps_o)
  );

  function automatic logic [31:0] b_vecword(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
  endfunction

  function automatic logic [31:0] b_vecaddr(input logic [31:0] tbr, input logic [7:0] n);
    logic [31:0] top = tbr + 32'd1024;
    return top - 32'd4 - {22'd0, n, 2'b00};
  endfunction

  function automatic logic [31:0] b_newps(input logic [31:0] ps, input bit dbg);
    logic [31:0] r = ps;
    r[5] = 1'b0;
    if (dbg) r[20:16] = 5'd4;
    else     r[4] = 1'b0;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic run_trap(input bit dbg, input logic [7:0] num, input logic [31:0] pc,
                          input logic [31:0] ps, input logic [31:0] ssp,
                          input logic [31:0] tbr, input int stall, input bit hold);
    logic [7:0]  en = dbg ? 8'd9 : num;
    logic [31:0] ea2 = b_vecaddr(tbr, en);
    logic [31:0] ea, ed;
    bit ewe, seen = 0, stalled = 0, rdy;
    int k = 0;
    string tg;
    @(negedge clk);
    req_i = 1'b1; dbg_i = dbg; num_i = num; pc_i = pc; ps_i = ps; ssp_i = ssp; tbr_i = tbr;
    @(negedge clk);
    if (!hold) req_i = 1'b0;
    else begin
      dbg_i = ~dbg; num_i = ~num; pc_i = pc ^ 32'h0000_FFFF; ps_i = ~ps;
      ssp_i = ssp + 32'd64; tbr_i = tbr + 32'd16;
    end
    for (int it = 0; it < 400 && !seen; it++) begin
      if (done_o) begin
        seen = 1;
        mem_ready_i = 1'b0;
        req_i = 1'b0;
        chk(k == 3, "R8 accesses before done", k, 3);
        chk(new_pc_o == b_vecword(ea2), "R4 new_pc", new_pc_o, b_vecword(ea2));
        chk(new_ssp_o == ssp - 32'd8, "R3 new_ssp", new_ssp_o, ssp - 32'd8);
        chk(new_ps_o == b_newps(ps, dbg), dbg ? "R6 new_ps" : "R5 new_ps",
            new_ps_o, b_newps(ps, dbg));
      end else if (mem_req_o) begin
        case (k)
          0: begin ewe = 1; ea = ssp - 32'd4; ed = ps;         tg = "R2 push ps"; end
          1: begin ewe = 1; ea = ssp - 32'd8; ed = pc + 32'd2; tg = "R3 push pc"; end
          default: begin ewe = 0; ea = ea2; ed = 32'd0; tg = dbg ? "R6 fetch" : "R4 fetch"; end
        endcase
        if (stalled) tg = "R7 held access";
        chk(k < 3, "R8 extra access", k, 2);
        chk(mem_we_o == ewe, tg, {31'd0, mem_we_o}, {31'd0, ewe});
        chk(mem_addr_o == ea, tg, mem_addr_o, ea);
        if (ewe) chk(mem_wdata_o == ed, tg, mem_wdata_o, ed);
        rdy = (stall == 0) || ($urandom_range(0, stall) == 0);
        mem_ready_i = rdy;
        mem_rdata_i = rdy ? b_vecword(mem_addr_o) : 32'hDEAD_BEEF;
        stalled = !rdy;
        if (rdy) k++;
      end else begin
        mem_ready_i = 1'b0;
      end
      if (!seen) @(negedge clk);
    end
    if (!seen) chk(1'b0, "R8 done never seen", 0, 1);
    @(negedge clk);
    chk(!done_o, "R8 done single cycle", {31'd0, done_o}, 0);
    chk(!mem_req_o, "R9 idle after done", {31'd0, mem_req_o}, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h2F1A_77C3));
    repeat (3) @(negedge clk);
    chk(!done_o && !mem_req_o, "R1 reset idle", {30'd0, done_o, mem_req_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done_o && !mem_req_o, "R1 idle after reset", {30'd0, done_o, mem_req_o}, 0);

    // Directed corners
    run_trap(0, 8'd0,   32'h0000_1000, 32'hFFFF_FFFF, 32'h0008_0000, 32'h000F_FC00, 0, 0); // R4 top entry, R5
    run_trap(0, 8'd255, 32'h0000_2000, 32'h0000_0030, 32'h0008_0000, 32'h000F_FC00, 0, 0); // R4 bottom entry
    run_trap(0, 8'd3,   32'hFFFF_FFFE, 32'h1234_5678, 32'h0000_0004, 32'hFFFF_FF00, 2, 0); // wrap
    run_trap(1, 8'h55,  32'h0000_4000, 32'h0000_0010, 32'h0001_0000, 32'h0000_0400, 0, 0); // R6 keeps I
    run_trap(1, 8'd0,   32'h0000_4444, 32'hABCD_EF3F, 32'h0001_0100, 32'h0000_8000, 3, 0); // R6
    run_trap(0, 8'd7,   32'h0000_5000, 32'h0000_00FF, 32'h0002_0000, 32'h0000_0C00, 4, 1); // R9 hold
    run_trap(1, 8'd200, 32'h0000_6000, 32'h00FF_0030, 32'h0003_0000, 32'h0000_1000, 1, 1); // R9 hold dbg

    // Random traffic
    for (int i = 0; i < 60; i++) begin
      run_trap($urandom_range(0, 3) == 0, 8'($urandom), $urandom & 32'hFFFF_FFFE,
               $urandom, $urandom & 32'hFFFF_FFFC, $urandom & 32'hFFFF_FC00,
               $urandom_range(0, 3), $urandom_range(0, 4) == 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule